// File: doc/BRIEF.md
# Capture and Classify Sequencing Controller

This control unit steps a camera-based handwritten-digit classifier through its working cycle. It first asks the camera-setup engine to program the sensor, with exposure and frame size among the settings. It then lets live pixels stream into image memory while the operator frames the digit. A take-photo press freezes that memory. The operator then looks at a thresholded black-and-white view of the frozen frame and either retakes it or starts classification. When the classifier finishes, the controller holds the answer on display.

Every datapath engine it talks to is reduced to a start strobe and a done flag. This covers the camera register setup, the display scan and the classifier arithmetic. The three operator buttons are active-low. Each is synchronised and edge-detected, so one press gives exactly one internal event however long the button is held. The retake button works from every state. It always sends the controller back to the setup state, which reprograms the camera before live capture resumes.

Top module: `capture_seq_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, `state_code` is 0 (setup). After the release, `cfg_start` pulses high exactly once.
- R2: A `cfg_done` pulse while in setup moves the controller to state 1 (live capture). The `cfg_done` input has no effect in any other state.
- R3: `img_wr_en` is 1 only in live capture, where `view_mode` is 0 (live view). In every other state `img_wr_en` is 0.
- R4: A take-photo press in live capture moves to state 2 (frame held), where `view_mode` is 1 (black-and-white). A take-photo press in any other state has no effect.
- R5: A retake press in any state leads to setup, with a fresh one-cycle `cfg_start`. If a retake event and `cfg_done` arrive in the same cycle, the retake wins.
- R6: A start press in the frame-held state moves to state 3 (classifying) and pulses `cls_start`. In state 3, `view_mode` stays 1. A start press in any other state has no effect.
- R7: A `cls_done` pulse while classifying moves to state 4 (result). There `result_latch` pulses once, `result_show` is 1 and `view_mode` is 2. The `cls_done` input has no effect in any other state.
- R8: The result state ignores take-photo, start, `cfg_done` and `cls_done`. Only a retake leaves it.
- R9: A button held low for many cycles produces a single event.
- R10: `cfg_start`, `cls_start` and `result_latch` each stay high for exactly one cycle per entry into their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| btn_retake_n | input | 1 | Retake button, active low |
| btn_shot_n | input | 1 | Take-photo button, active low |
| btn_go_n | input | 1 | Start-classification button, active low |
| cfg_done | input | 1 | Camera setup finished (pulse) |
| cls_done | input | 1 | Classifier finished (pulse) |
| state_code | output | 3 | 0 setup, 1 live, 2 held, 3 classifying, 4 result |
| cfg_start | output | 1 | One-cycle camera setup request |
| img_wr_en | output | 1 | Image memory write enable |
| view_mode | output | 2 | 0 live, 1 black-and-white, 2 result |
| cls_start | output | 1 | One-cycle classification request |
| result_latch | output | 1 | One-cycle pulse to capture the classifier answer |
| result_show | output | 1 | High while the result is presented |

## Verification
The hardest case to reach from the ports is a retake event that lands in the same cycle as `cfg_done`. Each button passes through a two-stage synchroniser and an edge register, so the event appears two clock edges after the pin falls. The stimulus drops the retake pin at a falling edge, counts two rising edges, and raises `cfg_done` for exactly the cycle in which the event is live. The bench then expects the controller to stay in setup and to issue a second setup strobe. Long button holds and presses of every button in the wrong state make up the other stimulus.

// File: rtl/capseq_pkg.sv
package capseq_pkg;

    localparam int NUM_BTN   = 3;
    localparam int BTN_RETAKE = 2;
    localparam int BTN_SHOT   = 1;
    localparam int BTN_GO     = 0;

    typedef enum logic [2:0] {
        ST_SETUP    = 3'd0,
        ST_LIVE     = 3'd1,
        ST_HELD     = 3'd2,
        ST_CLASSIFY = 3'd3,
        ST_RESULT   = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        VIEW_LIVE   = 2'd0,
        VIEW_BW     = 2'd1,
        VIEW_RESULT = 2'd2
    } view_e;

    typedef struct packed {
        logic retake;
        logic shot;
        logic go;
    } btn_evt_t;

    typedef struct packed {
        logic cfg_start;
        logic cls_start;
        logic res_latch;
    } strobe_t;

    function automatic view_e view_of(seq_state_e s);
        case (s)
            ST_HELD, ST_CLASSIFY: return VIEW_BW;
            ST_RESULT:            return VIEW_RESULT;
            default:              return VIEW_LIVE;
        endcase
    endfunction

endpackage

// File: rtl/capseq_btn.sv
module capseq_btn #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic press
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ~btn_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[MSB-1:0], ~btn_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[MSB];
    end

    assign press = sync_q[MSB] & ~prev_q;

    p_single_press_r9: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);

endmodule

// File: rtl/capseq_fsm.sv
module capseq_fsm
    import capseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  btn_evt_t   ev,
    input  logic       cfg_done,
    input  logic       cls_done,
    output seq_state_e state,
    output strobe_t    strobe
);
    seq_state_e state_q, state_d;
    strobe_t    strobe_q;
    logic       boot_q;

    always_comb begin
        state_d = state_q;
        if (ev.retake) begin
            state_d = ST_SETUP;
        end else begin
            unique case (state_q)
                ST_SETUP:    if (cfg_done) state_d = ST_LIVE;
                ST_LIVE:     if (ev.shot)  state_d = ST_HELD;
                ST_HELD:     if (ev.go)    state_d = ST_CLASSIFY;
                ST_CLASSIFY: if (cls_done) state_d = ST_RESULT;
                ST_RESULT:   state_d = ST_RESULT;
                default:     state_d = ST_SETUP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_SETUP;
            strobe_q <= '0;
            boot_q   <= 1'b1;
        end else begin
            state_q            <= state_d;
            boot_q             <= 1'b0;
            strobe_q.cfg_start <= (state_d == ST_SETUP) &&
                                  (boot_q || ev.retake || state_q != ST_SETUP);
            strobe_q.cls_start <= (state_d == ST_CLASSIFY) && (state_q != ST_CLASSIFY);
            strobe_q.res_latch <= (state_d == ST_RESULT) && (state_q != ST_RESULT);
        end
    end

    assign state  = state_q;
    assign strobe = strobe_q;

    p_retake_to_setup_r5: assert property (@(posedge clk) disable iff (rst)
        ev.retake |=> state_q == ST_SETUP);
    p_setup_done_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETUP && cfg_done && !ev.retake) |=> state_q == ST_LIVE);
    p_result_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESULT && !ev.retake) |=> state_q == ST_RESULT);
    p_cfg_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        strobe_q.cfg_start |=> !strobe_q.cfg_start);
    p_cls_in_classify_r6: assert property (@(posedge clk) disable iff (rst)
        strobe_q.cls_start |-> state_q == ST_CLASSIFY);
    p_latch_in_result_r7: assert property (@(posedge clk) disable iff (rst)
        strobe_q.res_latch |-> state_q == ST_RESULT);

endmodule

// File: rtl/capseq_decode.sv
module capseq_decode
    import capseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state,
    output logic       img_wr_en,
    output view_e      view,
    output logic       res_show
);
    assign img_wr_en = (state == ST_LIVE);
    assign view      = view_of(state);
    assign res_show  = (state == ST_RESULT);

    p_write_only_live_r3: assert property (@(posedge clk) disable iff (rst)
        img_wr_en |-> (view == VIEW_LIVE && !res_show));

endmodule

// File: rtl/capture_seq_ctrl.sv
module capture_seq_ctrl
    import capseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_retake_n,
    input  logic       btn_shot_n,
    input  logic       btn_go_n,
    input  logic       cfg_done,
    input  logic       cls_done,
    output logic [2:0] state_code,
    output logic       cfg_start,
    output logic       img_wr_en,
    output logic [1:0] view_mode,
    output logic       cls_start,
    output logic       result_latch,
    output logic       result_show
);
    logic [NUM_BTN-1:0] pin_n;
    logic [NUM_BTN-1:0] press;
    btn_evt_t           ev;
    seq_state_e         state;
    strobe_t            strobe;
    view_e              view;

    assign pin_n[BTN_RETAKE] = btn_retake_n;
    assign pin_n[BTN_SHOT]   = btn_shot_n;
    assign pin_n[BTN_GO]     = btn_go_n;

    generate
        for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
            capseq_btn #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
                .clk   (clk),
                .rst   (rst),
                .btn_n (pin_n[i]),
                .press (press[i])
            );
        end
    endgenerate

    assign ev.retake = press[BTN_RETAKE];
    assign ev.shot   = press[BTN_SHOT];
    assign ev.go     = press[BTN_GO];

    capseq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .cfg_done (cfg_done),
        .cls_done (cls_done),
        .state    (state),
        .strobe   (strobe)
    );

    capseq_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .img_wr_en (img_wr_en),
        .view      (view),
        .res_show  (result_show)
    );

    assign state_code   = state;
    assign view_mode    = view;
    assign cfg_start    = strobe.cfg_start;
    assign cls_start    = strobe.cls_start;
    assign result_latch = strobe.res_latch;

endmodule

// File: tb/sim_capture_seq_ctrl.sv
`timescale 1ns/1ps
module sim_capture_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_retake_n = 1'b1, btn_shot_n = 1'b1, btn_go_n = 1'b1;
    logic       cfg_done = 1'b0, cls_done = 1'b0;
    logic [2:0] state_code;
    logic       cfg_start, img_wr_en, cls_start, result_latch, result_show;
    logic [1:0] view_mode;

    always #2.5 clk = ~clk;

    capture_seq_ctrl u0 (
        .clk(clk), .rst(rst),
        .btn_retake_n(btn_retake_n), .btn_shot_n(btn_shot_n), .btn_go_n(btn_go_n),
        .cfg_done(cfg_done), .cls_done(cls_done),
        .state_code(state_code), .cfg_start(cfg_start), .img_wr_en(img_wr_en),
        .view_mode(view_mode), .cls_start(cls_start),
        .result_latch(result_latch), .result_show(result_show)
    );

    typedef struct {
        logic [2:0] st;
        logic       wr;
        logic [1:0] vw;
        logic       show;
        string      tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   checks = 0, errors = 0;
    int   n_cfg = 0, n_cls = 0, n_lat = 0;
    int   e_cfg = 0, e_cls = 0, e_lat = 0;
    bit   done_flag = 0;

    always @(negedge clk) begin
        if (cfg_start)    n_cfg++;
        if (cls_start)    n_cls++;
        if (result_latch) n_lat++;
    end

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (state_code !== e.st || img_wr_en !== e.wr ||
                    view_mode !== e.vw || result_show !== e.show) begin
                    errors++;
                    $display("FAIL %s: got st=%0d wr=%0b view=%0d show=%0b exp st=%0d wr=%0b view=%0d show=%0b",
                             e.tag, state_code, img_wr_en, view_mode, result_show,
                             e.st, e.wr, e.vw, e.show);
                end
            end
        end
    end

    task automatic expect_state(input logic [2:0] st, input string tag);
        exp_t e;
        e.st   = st;
        e.wr   = (st == 3'd1);
        e.vw   = (st == 3'd4) ? 2'd2 : ((st == 3'd2 || st == 3'd3) ? 2'd1 : 2'd0);
        e.show = (st == 3'd4);
        e.tag  = tag;
        q.push_back(e);
        -> chk_ev;
        #0;
    endtask

    task automatic chk_count(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic chk_pulses(input string tag);
        chk_count({tag, " cfg_start count"}, n_cfg, e_cfg);
        chk_count({tag, " cls_start count"}, n_cls, e_cls);
        chk_count({tag, " result_latch count"}, n_lat, e_lat);
    endtask

    // which: 2 retake, 1 shot, 0 go
    task automatic press(input int which, input int hold);
        @(negedge clk);
        if (which == 2) btn_retake_n = 1'b0;
        if (which == 1) btn_shot_n   = 1'b0;
        if (which == 0) btn_go_n     = 1'b0;
        repeat (hold) @(negedge clk);
        btn_retake_n = 1'b1; btn_shot_n = 1'b1; btn_go_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_cfg_done();
        @(negedge clk) cfg_done = 1'b1;
        @(negedge clk) cfg_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_cls_done();
        @(negedge clk) cls_done = 1'b1;
        @(negedge clk) cls_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // retake event and cfg_done land in the same cycle
    task automatic retake_with_done();
        @(negedge clk) btn_retake_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) cfg_done = 1'b1;
        @(negedge clk) cfg_done = 1'b0;
        repeat (3) @(negedge clk);
        btn_retake_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_state(3'd0, "R1 state during reset");
        chk_count("R1 no cfg_start in reset", n_cfg, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        e_cfg = 1;
        expect_state(3'd0, "R1 setup after reset");
        chk_pulses("R1 R10 boot");

        pulse_cfg_done();
        expect_state(3'd1, "R2 R3 live after cfg_done");

        press(0, 4);
        expect_state(3'd1, "R6 go ignored in live");
        pulse_cls_done();
        expect_state(3'd1, "R7 cls_done ignored in live");
        chk_pulses("R6 R7 ignored");

        press(1, 4);
        expect_state(3'd2, "R4 held after shot");
        pulse_cfg_done();
        expect_state(3'd2, "R2 cfg_done ignored in held");
        press(1, 4);
        expect_state(3'd2, "R4 shot ignored in held");

        press(2, 4);
        e_cfg++;
        expect_state(3'd0, "R5 retake from held");
        chk_pulses("R5 retake");

        press(1, 4);
        expect_state(3'd0, "R4 shot ignored in setup");

        retake_with_done();
        e_cfg++;
        expect_state(3'd0, "R5 retake beats cfg_done");
        chk_pulses("R5 simultaneous");

        pulse_cfg_done();
        press(1, 4);
        press(0, 4);
        e_cls++;
        expect_state(3'd3, "R6 classifying after go");
        chk_pulses("R6 R10 cls_start");
        press(2, 4);
        e_cfg++;
        expect_state(3'd0, "R5 retake from classifying");
        pulse_cls_done();
        expect_state(3'd0, "R7 cls_done ignored in setup");

        pulse_cfg_done();
        press(1, 4);
        press(0, 4);
        e_cls++;
        pulse_cls_done();
        e_lat++;
        expect_state(3'd4, "R7 result after cls_done");
        chk_pulses("R7 R10 result_latch");

        press(1, 4);
        press(0, 4);
        pulse_cls_done();
        pulse_cfg_done();
        expect_state(3'd4, "R8 result holds");
        chk_pulses("R8 no extra strobes");

        press(2, 40);
        e_cfg++;
        expect_state(3'd0, "R9 R5 long retake hold");
        chk_pulses("R9 single event");

        pulse_cfg_done();
        press(1, 50);
        expect_state(3'd2, "R9 long shot hold");
        chk_pulses("R9 R10 final");

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule